// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells an out-of-order core which earlier store a newly fetched load or store should wait for. It learns from memory ordering violations that the core has already detected. It keeps two direct-mapped tables. The first is indexed by instruction address and gives a set number. The second is indexed by set number and records the dynamic tag of the newest fetched store of that set.

Every load or store is presented in program order on a valid/ready request channel. It carries its address, a store flag and its dynamic tag. One cycle after a request is accepted, a registered response gives the tag of the store to wait for, if there is one. The response channel has back-pressure: while a response is held (`rsp_valid` high, `rsp_ready` low), `req_ready` is low and no request takes effect. A request is accepted only on a cycle where `req_valid` and `req_ready` are both high, and a response leaves only on a cycle where `rsp_valid` and `rsp_ready` are both high.

Two plain pulse inputs complete the block. The violation input places a colliding load and store into one set. The store-issue input releases a recorded store once it has executed. After a fixed count of accepted requests, all set membership is wiped.

Top module: `store_set_predictor`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1, and every address table entry is invalid.
- R2: The response for an accepted request appears in the cycle after acceptance. When the instruction has no valid set, or its set records no store, `rsp_has_dep` is 0 and `rsp_dep_tag` is 0.
- R3: A violation in which neither instruction has a valid set gives both instructions a new set number. That number comes from an allocation counter that starts at 0 after reset and wraps modulo the number of sets. A later load of that set then waits on the newest store of that set.
- R4: A violation in which exactly one of the two instructions has a valid set places the other instruction into that set.
- R5: A violation in which both instructions have valid sets writes the smaller of the two set numbers into both entries.
- R6: An accepted store with a valid set first reads the recorded store of its set as its own dependence. It then becomes the recorded store of that set. Stores of one set are therefore chained in fetch order, and a load gets the newest one.
- R7: A store-issue pulse looks up the set of the issuing address. It clears the recorded store of that set only if the recorded tag equals the issuing tag. With a different tag it has no effect.
- R8: The accepted request that completes each run of CLEAR_PERIOD accepted requests invalidates every address table entry. The lookup of that request still uses the old contents.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and the response fields hold steady. A request that is not accepted changes nothing.
- R10: The address table index is `pc[IDX_W+1:2]`. Addresses that share those bits share one entry.
- R11: In one cycle, a store fetch that writes a set wins over a store-issue clear of that same set. A table clear wins over a violation write.

Ports table notes: in the table below, P is PC_W and T is TAG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted when high |
| req_pc | input | P | Instruction address |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_tag | input | T | Dynamic tag of the instruction |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_has_dep | output | 1 | Instruction must wait for a store |
| rsp_dep_tag | output | T | Tag of that store, 0 when none |
| viol_valid | input | 1 | Violation report pulse |
| viol_load_pc | input | P | Address of the violating load |
| viol_store_pc | input | P | Address of the violating store |
| iss_valid | input | 1 | Store issue pulse |
| iss_pc | input | P | Address of the issuing store |
| iss_tag | input | T | Tag of the issuing store |

## Verification
The hardest case to reach from the ports is the periodic wipe. It interacts with the last-store table, which is not wiped, and with the wrapping allocation counter. After the wipe, a fresh set reuses a number whose last-store entry is still valid. The bench counts every accepted request itself and pads with fetches from an address that belongs to no set, so the wipe lands on a known cycle. It then allocates enough new sets to wrap the counter and shows that a load in the reused set waits on the stale store. A long pseudo-random sweep over a 16-entry table, including aliased addresses, is then compared against an arithmetic model of the two tables.

// File: rtl/sset_pkg.sv
package sset_pkg;
  typedef enum logic [1:0] {
    VK_NEW   = 2'd0,
    VK_LOAD  = 2'd1,
    VK_STORE = 2'd2,
    VK_BOTH  = 2'd3
  } viol_kind_e;
endpackage

// File: rtl/sset_pc_table.sv
module sset_pc_table #(
  parameter int IDX_W = 10,
  parameter int ID_W  = 8,
  parameter int NRD   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0][ID_W-1:0]   rd_id,
  output logic [NRD-1:0]             rd_vld,
  input  logic                       we,
  input  logic [IDX_W-1:0]           wa0,
  input  logic [IDX_W-1:0]           wa1,
  input  logic [ID_W-1:0]            wd,
  output logic [(1<<IDX_W)-1:0]      vld_vec
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ID_W-1:0]  id_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_id[g]  = id_q[rd_idx[g]];
    assign rd_vld[g] = vld_q[rd_idx[g]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr) begin
      vld_q <= '0;
    end else if (we) begin
      vld_q[wa0] <= 1'b1;
      vld_q[wa1] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !clr) begin
      id_q[wa0] <= wd;
      id_q[wa1] <= wd;
    end
  end

  assign vld_vec = vld_q;
endmodule

// File: rtl/sset_last_store.sv
module sset_last_store #(
  parameter int ID_W  = 8,
  parameter int TAG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ID_W-1:0]  rid,
  output logic             rvld,
  output logic [TAG_W-1:0] rtag,
  input  logic             we,
  input  logic [ID_W-1:0]  wid,
  input  logic [TAG_W-1:0] wtag,
  input  logic             ce,
  input  logic [ID_W-1:0]  cid,
  input  logic [TAG_W-1:0] ctag
);
  localparam int NSET = 1 << ID_W;

  logic [TAG_W-1:0] tag_q [NSET];
  logic [NSET-1:0]  vld_q;
  logic             release_hit;

  assign rvld = vld_q[rid];
  assign rtag = tag_q[rid];

  // Issue releases only when the recorded store is the one issuing and
  // no fetch writes the same set this cycle.
  assign release_hit = ce && vld_q[cid] && (tag_q[cid] == ctag)
                       && !(we && (wid == cid));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (release_hit) vld_q[cid] <= 1'b0;
      if (we)          vld_q[wid] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) tag_q[wid] <= wtag;
  end
endmodule

// File: rtl/sset_merge.sv
module sset_merge
  import sset_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            ld_vld,
  input  logic [ID_W-1:0] ld_id,
  input  logic            st_vld,
  input  logic [ID_W-1:0] st_id,
  output logic [ID_W-1:0] new_id
);
  logic [ID_W-1:0] alloc_q;
  viol_kind_e      kind;

  always_comb begin
    kind = viol_kind_e'({st_vld, ld_vld});
    unique case (kind)
      VK_NEW:   new_id = alloc_q;
      VK_LOAD:  new_id = ld_id;
      VK_STORE: new_id = st_id;
      VK_BOTH:  new_id = (ld_id < st_id) ? ld_id : st_id;
      default:  new_id = alloc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        alloc_q <= '0;
    else if (fire && (kind == VK_NEW)) alloc_q <= alloc_q + 1'b1;
  end
endmodule

// File: rtl/sset_clear_timer.sv
module sset_clear_timer #(
  parameter int PERIOD = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic clr
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign clr = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr)   cnt_q <= '0;
    else if (tick)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W         = 32,
  parameter int IDX_W        = 10,
  parameter int ID_W         = 8,
  parameter int TAG_W        = 7,
  parameter int CLEAR_PERIOD = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PC_W-1:0]  req_pc,
  input  logic             req_is_store,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_has_dep,
  output logic [TAG_W-1:0] rsp_dep_tag,
  input  logic             viol_valid,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic [PC_W-1:0]  viol_store_pc,
  input  logic             iss_valid,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [TAG_W-1:0] iss_tag
);
  localparam int NRD    = 4;
  localparam int RP_FET = 0;
  localparam int RP_VLD = 1;
  localparam int RP_VST = 2;
  localparam int RP_ISS = 3;

  logic                      acc;
  logic                      clr_pulse;
  logic [NRD-1:0][IDX_W-1:0] rd_idx;
  logic [NRD-1:0][ID_W-1:0]  rd_id;
  logic [NRD-1:0]            rd_vld;
  logic [ID_W-1:0]           merged_id;
  logic [(1<<IDX_W)-1:0]     pc_vld_vec;
  logic                      ls_vld;
  logic [TAG_W-1:0]          ls_tag;
  logic                      hit;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  assign rd_idx[RP_FET] = req_pc[IDX_W+1:2];
  assign rd_idx[RP_VLD] = viol_load_pc[IDX_W+1:2];
  assign rd_idx[RP_VST] = viol_store_pc[IDX_W+1:2];
  assign rd_idx[RP_ISS] = iss_pc[IDX_W+1:2];

  sset_pc_table #(.IDX_W(IDX_W), .ID_W(ID_W), .NRD(NRD)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_pulse),
    .rd_idx  (rd_idx),
    .rd_id   (rd_id),
    .rd_vld  (rd_vld),
    .we      (viol_valid),
    .wa0     (rd_idx[RP_VLD]),
    .wa1     (rd_idx[RP_VST]),
    .wd      (merged_id),
    .vld_vec (pc_vld_vec)
  );

  sset_merge #(.ID_W(ID_W)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (viol_valid),
    .ld_vld (rd_vld[RP_VLD]),
    .ld_id  (rd_id[RP_VLD]),
    .st_vld (rd_vld[RP_VST]),
    .st_id  (rd_id[RP_VST]),
    .new_id (merged_id)
  );

  sset_last_store #(.ID_W(ID_W), .TAG_W(TAG_W)) u_last (
    .clk   (clk),
    .rst_n (rst_n),
    .rid   (rd_id[RP_FET]),
    .rvld  (ls_vld),
    .rtag  (ls_tag),
    .we    (acc && req_is_store && rd_vld[RP_FET]),
    .wid   (rd_id[RP_FET]),
    .wtag  (req_tag),
    .ce    (iss_valid && rd_vld[RP_ISS]),
    .cid   (rd_id[RP_ISS]),
    .ctag  (iss_tag)
  );

  sset_clear_timer #(.PERIOD(CLEAR_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (acc),
    .clr   (clr_pulse)
  );

  assign hit = rd_vld[RP_FET] && ls_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_has_dep <= 1'b0;
      rsp_dep_tag <= '0;
    end else if (acc) begin
      rsp_valid   <= 1'b1;
      rsp_has_dep <= hit;
      rsp_dep_tag <= hit ? ls_tag : '0;
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/store_set_checks.sv
module store_set_checks #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10,
  parameter int TAG_W = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic                  rsp_has_dep,
  input logic [TAG_W-1:0]      rsp_dep_tag,
  input logic                  viol_valid,
  input logic [PC_W-1:0]       viol_load_pc,
  input logic [PC_W-1:0]       viol_store_pc,
  input logic                  clr_pulse,
  input logic [(1<<IDX_W)-1:0] pc_vld_vec
);
  logic [IDX_W-1:0] ld_idx;
  logic [IDX_W-1:0] st_idx;
  assign ld_idx = viol_load_pc[IDX_W+1:2];
  assign st_idx = viol_store_pc[IDX_W+1:2];

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_has_dep) && $stable(rsp_dep_tag)));

  // R2
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // R8
  table_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> (pc_vld_vec == '0));

  // R3
  viol_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !clr_pulse) |=>
      (pc_vld_vec[$past(ld_idx)] && pc_vld_vec[$past(st_idx)]));
endmodule

bind store_set_predictor store_set_checks #(
  .PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_has_dep   (rsp_has_dep),
  .rsp_dep_tag   (rsp_dep_tag),
  .viol_valid    (viol_valid),
  .viol_load_pc  (viol_load_pc),
  .viol_store_pc (viol_store_pc),
  .clr_pulse     (clr_pulse),
  .pc_vld_vec    (pc_vld_vec)
);

// File: tb/sim_store_set_predictor.sv
module sim_store_set_predictor;
  localparam int PC_W   = 32;
  localparam int IDX_W  = 4;
  localparam int ID_W   = 2;
  localparam int TAG_W  = 6;
  localparam int PERIOD = 50;
  localparam int NENT   = 1 << IDX_W;
  localparam int NSET   = 1 << ID_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_store = 1'b0, rsp_ready = 1'b1;
  logic [PC_W-1:0] req_pc = '0, viol_load_pc = '0, viol_store_pc = '0, iss_pc = '0;
  logic [TAG_W-1:0] req_tag = '0, iss_tag = '0;
  logic viol_valid = 1'b0, iss_valid = 1'b0;
  logic req_ready, rsp_valid, rsp_has_dep;
  logic [TAG_W-1:0] rsp_dep_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  store_set_predictor #(
    .PC_W(PC_W), .IDX_W(IDX_W), .ID_W(ID_W), .TAG_W(TAG_W), .CLEAR_PERIOD(PERIOD)
  ) u0 (.*);

  // arithmetic model of both tables
  int m_id [NENT];
  bit m_sv [NENT];
  bit m_lv [NSET];
  int m_lt [NSET];
  int m_alloc = 0;
  int m_cnt = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int ix(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  task automatic m_fetch(input logic [PC_W-1:0] pc, input bit st, input int tag,
                         output bit eh, output int et);
    int i = ix(pc);
    eh = m_sv[i] && m_lv[m_id[i]];
    et = eh ? m_lt[m_id[i]] : 0;
    if (st && m_sv[i]) begin
      m_lv[m_id[i]] = 1'b1;
      m_lt[m_id[i]] = tag;
    end
    m_cnt++;
    if (m_cnt == PERIOD) begin
      m_cnt = 0;
      for (int k = 0; k < NENT; k++) m_sv[k] = 1'b0;
    end
  endtask

  task automatic m_viol(input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc);
    int a = ix(lpc);
    int b = ix(spc);
    int n;
    if (m_sv[a] && m_sv[b]) n = (m_id[a] < m_id[b]) ? m_id[a] : m_id[b];
    else if (m_sv[a]) n = m_id[a];
    else if (m_sv[b]) n = m_id[b];
    else begin
      n = m_alloc;
      m_alloc = (m_alloc + 1) % NSET;
    end
    m_sv[a] = 1'b1; m_id[a] = n;
    m_sv[b] = 1'b1; m_id[b] = n;
  endtask

  task automatic m_iss(input logic [PC_W-1:0] pc, input int tag);
    int i = ix(pc);
    if (m_sv[i] && m_lv[m_id[i]] && m_lt[m_id[i]] == tag) m_lv[m_id[i]] = 1'b0;
  endtask

  task automatic fetch(input logic [PC_W-1:0] pc, input bit st, input int tag,
                       output bit h, output int t);
    bit eh;
    int et;
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc; req_is_store = st; req_tag = TAG_W'(tag);
    @(negedge clk);
    req_valid = 1'b0;
    h = rsp_has_dep; t = int'(rsp_dep_tag);
    m_fetch(pc, st, tag, eh, et);
    chk(rsp_valid == 1'b1, "R2 response valid", int'(rsp_valid), 1);
    chk(h == eh && t == et, "R6 model lookup", t + (h ? 1000 : 0), et + (eh ? 1000 : 0));
  endtask

  task automatic viol(input logic [PC_W-1:0] lpc, input logic [PC_W-1:0] spc);
    @(negedge clk);
    viol_valid = 1'b1; viol_load_pc = lpc; viol_store_pc = spc;
    @(negedge clk);
    viol_valid = 1'b0;
    m_viol(lpc, spc);
  endtask

  task automatic issue(input logic [PC_W-1:0] pc, input int tag);
    @(negedge clk);
    iss_valid = 1'b1; iss_pc = pc; iss_tag = TAG_W'(tag);
    @(negedge clk);
    iss_valid = 1'b0;
    m_iss(pc, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit h;
    int t;
    logic [15:0] lf = 16'hACE1;
    int tg = 30;
    for (int k = 0; k < NENT; k++) begin m_sv[k] = 0; m_id[k] = 0; end
    for (int k = 0; k < NSET; k++) begin m_lv[k] = 0; m_lt[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    fetch(32'h04, 0, 1, h, t);
    chk(h == 0 && t == 0, "R2 no set", t, 0);

    // R3 new set from empty
    viol(32'h04, 32'h08);
    fetch(32'h08, 1, 5, h, t);
    chk(h == 0, "R3 first store no dep", int'(h), 0);
    fetch(32'h04, 0, 6, h, t);
    chk(h == 1 && t == 5, "R3 load waits", t, 5);

    // R6 store chaining
    fetch(32'h08, 1, 7, h, t);
    chk(h == 1 && t == 5, "R6 store chained", t, 5);
    fetch(32'h04, 0, 8, h, t);
    chk(h == 1 && t == 7, "R6 newest store", t, 7);

    // R7 issue release
    issue(32'h08, 5);
    fetch(32'h04, 0, 8, h, t);
    chk(h == 1 && t == 7, "R7 mismatch ignored", t, 7);
    issue(32'h08, 7);
    fetch(32'h04, 0, 8, h, t);
    chk(h == 0, "R7 released", int'(h), 0);

    // R4 join existing set
    viol(32'h10, 32'h08);
    fetch(32'h08, 1, 9, h, t);
    fetch(32'h10, 0, 10, h, t);
    chk(h == 1 && t == 9, "R4 load joined", t, 9);

    // R5 both in sets: smaller number wins
    viol(32'h14, 32'h18);
    viol(32'h14, 32'h08);
    fetch(32'h18, 1, 11, h, t);
    chk(h == 0, "R5 other set untouched", int'(h), 0);
    fetch(32'h14, 0, 12, h, t);
    chk(h == 1 && t == 9, "R5 load moved to smaller", t, 9);

    // R10 aliasing
    fetch(32'h44, 0, 13, h, t);
    chk(h == 1 && t == 9, "R10 alias shares entry", t, 9);

    // R11 store fetch beats issue release
    @(negedge clk);
    req_valid = 1; req_pc = 32'h08; req_is_store = 1; req_tag = 6'd14;
    iss_valid = 1; iss_pc = 32'h08; iss_tag = 6'd9;
    @(negedge clk);
    req_valid = 0; iss_valid = 0;
    chk(rsp_has_dep == 1 && rsp_dep_tag == 6'd9, "R11 store read", int'(rsp_dep_tag), 9);
    m_fetch(32'h08, 1, 14, h, t);
    fetch(32'h04, 0, 15, h, t);
    chk(h == 1 && t == 14, "R11 fetch write wins", t, 14);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_pc = 32'h04; req_is_store = 0; req_tag = 6'd16;
    @(negedge clk);
    m_fetch(32'h04, 0, 16, h, t);
    req_pc = 32'h08; req_is_store = 1; req_tag = 6'd20;
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      chk(req_ready == 0, "R9 req_ready low", int'(req_ready), 0);
      chk(rsp_valid == 1 && rsp_dep_tag == 6'd14, "R9 held", int'(rsp_dep_tag), 14);
    end
    req_valid = 0;
    @(negedge clk);
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R9 drained", int'(rsp_valid), 0);
    fetch(32'h04, 0, 17, h, t);
    chk(h == 1 && t == 14, "R9 stalled store no effect", t, 14);

    // R8 periodic wipe
    while (m_cnt != PERIOD - 1) fetch(32'h3C, 0, 0, h, t);
    fetch(32'h04, 0, 18, h, t);
    chk(h == 1 && t == 14, "R8 last lookup old", t, 14);
    fetch(32'h04, 0, 19, h, t);
    chk(h == 0, "R8 wiped", int'(h), 0);

    // R3 counter wrap reuses set 0 whose last store is still 14
    viol(32'h20, 32'h24);
    viol(32'h28, 32'h2C);
    viol(32'h30, 32'h34);
    fetch(32'h30, 0, 21, h, t);
    chk(h == 1 && t == 14, "R3 wrap reuse", t, 14);

    // sweep against the model
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [PC_W-1:0] pa, pb;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = int'(lf[2:0]);
      pa = PC_W'({lf[8:4] % 5'd24, 2'b00});
      pb = PC_W'({lf[13:9] % 5'd24, 2'b00});
      if (op < 5) begin
        tg = (tg + 1) % 64;
        fetch(pa, lf[3], tg, h, t);
      end else if (op < 7) viol(pa, pb);
      else issue(pa, lf[15] ? tg : int'(lf[9:4]));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule